// File: doc/BRIEF.md
# Protected Control Register Sequencer

This block holds the 8-bit configuration register of a serial memory with supply supervision. The register's watchdog-period field, block-protect code and hardware-lock enable are nonvolatile. They can change only after a three-step sequence: a byte sets the write-enable latch, a second byte arms the register-write latch, and a third byte commits the new field values. The block also decodes the block-protect code and the external write-protect pin into a per-address write-allowed flag, which the memory write path uses.

The bus front end delivers register traffic as strobes. `reg_wr` carries one data byte, and `reg_first` marks the first byte of a transfer. `reg_stop` marks the stop condition that ends the transfer, and `reg_rd` marks a register read. Each byte is answered with an acknowledge decision one cycle later. The decision made on the first byte takes effect at the stop. A commit also raises a one-cycle pulse that starts the nonvolatile cycle. The nonvolatile fields are modelled as flops with reset defaults.

Register bit positions (these are decoded by software): bit 7 hardware-lock enable, bits 6:5 watchdog period, bits 4:3 block-protect bits 1:0, bit 2 register-write latch, bit 1 write-enable latch, bit 0 block-protect bit 2.

Top module: `pcr_ctrl_seq`

## Requirements
- R1: After reset `ctrl_q` reads 60h: watchdog field 11, block-protect code 000, lock enable 0, both latches 0.
- R2: With the register-write latch clear, these first bytes are handled as follows. A byte of 02h is acknowledged and sets the write-enable latch at the stop. A byte of 00h is acknowledged only while the write-enable latch is set, and clears it at the stop. Any other byte except 06h is not acknowledged and changes nothing.
- R3: A first byte of 06h with the write-enable latch set is acknowledged, and at the stop it sets the register-write latch (bit 2). With the write-enable latch clear, the same byte is not acknowledged and changes nothing. The register-write latch is never set while the write-enable latch is clear.
- R4: With the register-write latch set, a first byte with bit 2 = 0 and bit 1 = 1 is a commit. It is acknowledged. At the stop it loads bits 7:3 and bit 0 from the byte and clears the register-write latch. It also pulses `nv_start` for exactly one cycle. The nonvolatile bits never change without that pulse. So the sequence 02h, 06h, 02h clears all of them.
- R5: With the register-write latch set, a first byte with bits 2 and 1 both 1 is acknowledged. It leaves the nonvolatile bits unchanged and keeps the latch set. So the sequence 02h, 06h, 06h changes nothing.
- R6: A byte with `reg_first` low is never acknowledged, and it cancels the pending action of its transfer. The following stop then changes nothing.
- R7: `reg_rd` copies `ctrl_q` into `rd_data` on the next cycle. A read does not disturb a sequence in progress.
- R8: The protected range for each block-protect code is as follows: 000 none; 001 1800h-1FFFh; 010 1000h-1FFFh; 011 all; 100 000h-03Fh; 101 000h-07Fh; 110 000h-0FFh; 111 000h-1FFh.
- R9: `wr_allowed` is high exactly when the write-enable latch is set and `mem_addr` is outside the protected range. A `mem_wr_try` to a protected address clears the register-write latch.
- R10: While `wp_pin` and the lock-enable bit are both high, a commit byte is not acknowledged and changes nothing. Unprotected addresses remain writable.
- R11: The acknowledge decision (`ack_vld`, `ack`) appears in the cycle after `reg_wr`. Register updates and `nv_start` appear in the cycle after `reg_stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register data byte strobe |
| reg_first | input | 1 | Byte is the first of the transfer |
| reg_data | input | 8 | Register data byte |
| reg_stop | input | 1 | Stop condition ending the register write |
| reg_rd | input | 1 | Register read strobe |
| wp_pin | input | 1 | External write-protect pin |
| mem_addr | input | 13 | Memory array address under test |
| mem_wr_try | input | 1 | A memory write to `mem_addr` is attempted |
| ctrl_q | output | 8 | Current register contents |
| rd_data | output | 8 | Register value captured by the last read |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge, 0 = not acknowledged |
| nv_start | output | 1 | One-cycle pulse starting a nonvolatile cycle |
| wr_allowed | output | 1 | Write to `mem_addr` is permitted |

## Verification
A wrong latch state appears at `ctrl_q` one cycle after the stop that set it. It appears again at the next byte, whose acknowledge decision would differ one cycle after `reg_wr`. A corrupted block-protect code shows at once on `wr_allowed` for addresses at the range edges, so those edges are probed directly. A stray nonvolatile update shows as a change of the top field bits without an `nv_start` pulse in the same cycle.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int REG_W = 8;
  localparam int B_LOCK = 7;
  localparam int B_RWL  = 2;
  localparam int B_WEL  = 1;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_SET_WEL,
    ACT_CLR_WEL,
    ACT_SET_RWL,
    ACT_HOLD,
    ACT_COMMIT
  } pcr_act_e;
endpackage

// File: rtl/pcr_prot_decode.sv
module pcr_prot_decode #(
  parameter int AW = 13,
  parameter int PW = 6
) (
  input  logic [2:0]    bp,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [AW-1:0] sh;

  always_comb begin
    sh  = addr >> (PW + int'(bp[1:0]));
    hit = 1'b0;
    case (bp)
      3'b000:  hit = 1'b0;
      3'b001:  hit = &addr[AW-1:AW-2];
      3'b010:  hit = addr[AW-1];
      3'b011:  hit = 1'b1;
      default: hit = (sh == '0);
    endcase
  end
endmodule

// File: rtl/pcr_cmd_decode.sv
module pcr_cmd_decode
  import pcr_pkg::*;
(
  input  logic             wel,
  input  logic             rwl,
  input  logic             locked,
  input  logic [REG_W-1:0] d,
  output pcr_act_e         act,
  output logic             ok
);
  always_comb begin
    act = ACT_NONE;
    if (rwl) begin
      if (d[B_WEL] && !d[B_RWL])     act = locked ? ACT_NONE : ACT_COMMIT;
      else if (d[B_WEL] && d[B_RWL]) act = ACT_HOLD;
    end else begin
      case (d)
        8'h02:   act = ACT_SET_WEL;
        8'h06:   act = wel ? ACT_SET_RWL : ACT_NONE;
        8'h00:   act = wel ? ACT_CLR_WEL : ACT_NONE;
        default: act = ACT_NONE;
      endcase
    end
    ok = (act != ACT_NONE);
  end
endmodule

// File: rtl/pcr_state_regs.sv
module pcr_state_regs
  import pcr_pkg::*;
#(
  parameter logic [1:0] RST_WD = 2'b11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_first,
  input  logic [REG_W-1:0] reg_data,
  input  logic             reg_stop,
  input  logic             reg_rd,
  input  pcr_act_e         cmd_act,
  input  logic             cmd_ok,
  input  logic             try_hit,
  input  logic [REG_W-1:0] cur_q,
  output logic             wel,
  output logic             rwl,
  output logic             lock_en,
  output logic [1:0]       wd,
  output logic [2:0]       bp,
  output logic             ack_vld,
  output logic             ack,
  output logic             nv_start,
  output logic [REG_W-1:0] rd_data
);
  logic             pend_vld;
  pcr_act_e         pend_act;
  logic [REG_W-1:0] pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel      <= 1'b0;
      rwl      <= 1'b0;
      lock_en  <= 1'b0;
      wd       <= RST_WD;
      bp       <= 3'b000;
      pend_vld <= 1'b0;
      pend_act <= ACT_NONE;
      pend_d   <= '0;
      ack_vld  <= 1'b0;
      ack      <= 1'b0;
      nv_start <= 1'b0;
      rd_data  <= '0;
    end else begin
      ack_vld  <= reg_wr;
      ack      <= reg_wr && reg_first && cmd_ok;
      nv_start <= 1'b0;
      if (reg_wr) begin
        if (reg_first) begin
          pend_vld <= cmd_ok;
          pend_act <= cmd_act;
          pend_d   <= reg_data;
        end else begin
          pend_vld <= 1'b0;
        end
      end
      if (reg_stop) begin
        pend_vld <= 1'b0;
        if (pend_vld) begin
          case (pend_act)
            ACT_SET_WEL: wel <= 1'b1;
            ACT_CLR_WEL: wel <= 1'b0;
            ACT_SET_RWL: begin
              wel <= 1'b1;
              rwl <= 1'b1;
            end
            ACT_COMMIT: begin
              lock_en  <= pend_d[7];
              wd       <= pend_d[6:5];
              bp       <= {pend_d[0], pend_d[4:3]};
              rwl      <= 1'b0;
              nv_start <= 1'b1;
            end
            default: ;
          endcase
        end
      end
      if (try_hit) rwl <= 1'b0;
      if (reg_rd) rd_data <= cur_q;
    end
  end
endmodule

// File: rtl/pcr_ctrl_seq.sv
module pcr_ctrl_seq
  import pcr_pkg::*;
#(
  parameter int AW = 13,
  parameter int PW = 6,
  parameter logic [1:0] RST_WD = 2'b11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_first,
  input  logic [7:0]    reg_data,
  input  logic          reg_stop,
  input  logic          reg_rd,
  input  logic          wp_pin,
  input  logic [AW-1:0] mem_addr,
  input  logic          mem_wr_try,
  output logic [7:0]    ctrl_q,
  output logic [7:0]    rd_data,
  output logic          ack_vld,
  output logic          ack,
  output logic          nv_start,
  output logic          wr_allowed
);
  logic       wel, rwl, lock_en, prot_hit;
  logic [1:0] wd;
  logic [2:0] bp;
  pcr_act_e   cmd_act;
  logic       cmd_ok;

  assign ctrl_q     = {lock_en, wd, bp[1:0], rwl, wel, bp[2]};
  assign wr_allowed = wel && !prot_hit;

  pcr_prot_decode #(.AW(AW), .PW(PW)) u_prot (
    .bp(bp), .addr(mem_addr), .hit(prot_hit)
  );

  pcr_cmd_decode u_cmd (
    .wel(wel), .rwl(rwl), .locked(wp_pin && lock_en),
    .d(reg_data), .act(cmd_act), .ok(cmd_ok)
  );

  pcr_state_regs #(.RST_WD(RST_WD)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_first(reg_first),
    .reg_data(reg_data), .reg_stop(reg_stop), .reg_rd(reg_rd),
    .cmd_act(cmd_act), .cmd_ok(cmd_ok), .try_hit(mem_wr_try && prot_hit),
    .cur_q(ctrl_q), .wel(wel), .rwl(rwl), .lock_en(lock_en), .wd(wd),
    .bp(bp), .ack_vld(ack_vld), .ack(ack), .nv_start(nv_start),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/pcr_ctrl_seq_chk.sv
module pcr_ctrl_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_first,
  input logic       reg_stop,
  input logic       ack_vld,
  input logic       ack,
  input logic       nv_start,
  input logic [7:0] ctrl_q,
  input logic       wr_allowed
);
  p_ack_after_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> $past(reg_wr));
  p_ack_has_vld_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ack_vld);
  p_later_byte_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_first) |=> !ack);
  p_nv_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start |-> $past(reg_stop));
  p_commit_drops_rwl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start |-> !ctrl_q[2]);
  p_nv_bits_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !nv_start |-> $stable({ctrl_q[7:3], ctrl_q[0]}));
  p_rwl_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[2] |-> ctrl_q[1]);
  p_no_wel_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[1] |-> !wr_allowed);
endmodule

bind pcr_ctrl_seq pcr_ctrl_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_first(reg_first),
  .reg_stop(reg_stop), .ack_vld(ack_vld), .ack(ack), .nv_start(nv_start),
  .ctrl_q(ctrl_q), .wr_allowed(wr_allowed)
);

// File: tb/pcr_ctrl_seq_test.sv
`timescale 1ns/1ps
module pcr_ctrl_seq_test;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_first = 0, reg_stop = 0, reg_rd = 0, wp_pin = 0, mem_wr_try = 0;
  logic [7:0] reg_data = 0;
  logic [12:0] mem_addr = 0;
  logic [7:0] ctrl_q, rd_data;
  logic ack_vld, ack, nv_start, wr_allowed;
  int compared = 0, mismatched = 0;
  bit done = 0;

  // bench model
  bit m_wel, m_rwl, m_lock;
  bit [1:0] m_wd;
  bit [2:0] m_bp;
  int m_pact;
  bit m_pvld;
  bit [7:0] m_pd;

  always #5 clk = ~clk;

  pcr_ctrl_seq uut (.*);

  function automatic bit [7:0] exp_q();
    return {m_lock, m_wd, m_bp[1:0], m_rwl, m_wel, m_bp[2]};
  endfunction

  // 0 none,1 set wel,2 clr wel,3 set rwl,4 hold,5 commit
  function automatic int exp_act(bit [7:0] d, bit wp);
    if (m_rwl) begin
      if (d[1] && !d[2]) return (wp && m_lock) ? 0 : 5;
      if (d[1] && d[2]) return 4;
      return 0;
    end
    if (d == 8'h02) return 1;
    if (d == 8'h06) return m_wel ? 3 : 0;
    if (d == 8'h00) return m_wel ? 2 : 0;
    return 0;
  endfunction

  function automatic bit exp_prot(bit [2:0] bp, bit [12:0] a);
    case (bp)
      3'd0: return 0;
      3'd1: return a >= 13'h1800;
      3'd2: return a >= 13'h1000;
      3'd3: return 1;
      3'd4: return a <= 13'h03F;
      3'd5: return a <= 13'h07F;
      3'd6: return a <= 13'h0FF;
      default: return a <= 13'h1FF;
    endcase
  endfunction

  task automatic chk(bit good, string req, int act, int exp);
    compared++;
    if (!good) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one register transfer: first byte, optional second byte, stop
  task automatic xfer(bit [7:0] d, bit extra, string req);
    int a;
    a = exp_act(d, wp_pin);
    @(negedge clk); reg_wr = 1; reg_first = 1; reg_data = d;
    @(negedge clk); reg_wr = 0; reg_first = 0;
    chk(ack_vld && ack == (a != 0), {req, " R11 ack"}, {ack_vld, ack}, {1'b1, a != 0});
    m_pvld = (a != 0); m_pact = a; m_pd = d;
    if (extra) begin
      reg_wr = 1; reg_data = $urandom;
      @(negedge clk); reg_wr = 0;
      chk(ack_vld && !ack, "R6 second byte nack", {ack_vld, ack}, 2'b10);
      m_pvld = 0;
    end
    reg_stop = 1;
    @(negedge clk); reg_stop = 0;
    if (m_pvld) begin
      case (m_pact)
        1: m_wel = 1;
        2: m_wel = 0;
        3: begin m_wel = 1; m_rwl = 1; end
        5: begin m_lock = m_pd[7]; m_wd = m_pd[6:5]; m_bp = {m_pd[0], m_pd[4:3]}; m_rwl = 0; end
        default: ;
      endcase
    end
    chk(nv_start == (m_pvld && m_pact == 5), {req, " R4 nv_start"}, nv_start, m_pvld && m_pact == 5);
    chk(ctrl_q == exp_q(), {req, " R11 ctrl_q"}, ctrl_q, exp_q());
    m_pvld = 0;
  endtask

  task automatic probe(bit [12:0] a, bit attempt, string req);
    bit p;
    p = exp_prot(m_bp, a);
    @(negedge clk); mem_addr = a;
    #1 chk(wr_allowed == (m_wel && !p), {req, " R9 wr_allowed"}, wr_allowed, m_wel && !p);
    if (attempt) begin
      mem_wr_try = 1;
      @(negedge clk); mem_wr_try = 0;
      if (p) m_rwl = 0;
      chk(ctrl_q == exp_q(), "R9 try clears rwl", ctrl_q, exp_q());
    end
  endtask

  task automatic do_read();
    bit [7:0] e;
    e = exp_q();
    @(negedge clk); reg_rd = 1;
    @(negedge clk); reg_rd = 0;
    chk(rd_data == e, "R7 read data", rd_data, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_wel = 0; m_rwl = 0; m_lock = 0; m_wd = 2'b11; m_bp = 0; m_pvld = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ctrl_q == 8'h60, "R1 reset value", ctrl_q, 8'h60);
    chk(!ack_vld && !nv_start, "R1 idle outputs", {ack_vld, nv_start}, 0);

    // R2/R3: 06h without wel, junk byte
    xfer(8'h06, 0, "R3 no wel");
    xfer(8'h55, 0, "R2 junk");
    xfer(8'h00, 0, "R2 clear without wel");
    // set bp=101, wd=01, via full sequence with read in between (R7)
    xfer(8'h02, 0, "R2 set wel");
    do_read();
    xfer(8'h06, 0, "R3 set rwl");
    do_read();
    xfer(8'b0010_1011, 0, "R4 commit");
    for (int i = 0; i < 8; i++) probe(13'h07D + 13'(i), 0, "R8 edge 07F");
    // R5 hold then commit 02h clears all
    xfer(8'h06, 0, "R3 rearm");
    xfer(8'h06, 0, "R5 hold");
    xfer(8'h02, 0, "R4 clear all");
    chk(ctrl_q == 8'h02, "R4 02 06 02 result", ctrl_q, 8'h02);
    // R6 abort
    xfer(8'h06, 0, "R6 arm");
    xfer(8'hFA, 1, "R6 abort");
    // protected attempt clears rwl (bp code 011 via commit)
    xfer(8'h1A, 0, "R4 full lock");
    xfer(8'h06, 0, "R9 arm");
    probe(13'h0123, 1, "R9 protected try");
    // R10 lock: set lock enable, bp 001
    xfer(8'h06, 0, "R10 arm");
    xfer(8'h8A, 0, "R10 set lock bit");
    wp_pin = 1;
    xfer(8'h06, 0, "R10 arm locked");
    xfer(8'h02, 0, "R10 commit blocked");
    probe(13'h17FF, 0, "R10 unprotected ok");
    probe(13'h1800, 0, "R10 protected edge");
    wp_pin = 0;
    xfer(8'h02, 0, "R10 commit unlocked");
    xfer(8'h00, 0, "R2 clear wel");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int k;
      bit [7:0] d;
      k = $urandom_range(0, 9);
      wp_pin = ($urandom_range(0, 4) == 0);
      case (k)
        0, 1: d = 8'h02;
        2, 3: d = 8'h06;
        4:    d = 8'h00;
        5, 6: d = ($urandom & 8'hF9) | 8'h02;
        default: d = $urandom;
      endcase
      xfer(d, ($urandom_range(0, 9) == 0), "rand");
      if ($urandom_range(0, 3) == 0) probe(13'($urandom), $urandom_range(0, 1), "rand");
      if ($urandom_range(0, 7) == 0) do_read();
    end
    wp_pin = 0;
    // sweep protect codes at range edges
    for (int c = 0; c < 8; c++) begin
      xfer(8'h02, 0, "R8 sweep wel");
      xfer(8'h06, 0, "R8 sweep arm");
      xfer({1'b0, 2'b11, 2'(c), 2'b01, 1'(c >> 2)}, 0, "R8 sweep commit");
      probe(13'h0000, 0, "R8"); probe(13'h003F, 0, "R8"); probe(13'h0040, 0, "R8");
      probe(13'h01FF, 0, "R8"); probe(13'h0200, 0, "R8"); probe(13'h0FFF, 0, "R8");
      probe(13'h1000, 0, "R8"); probe(13'h17FF, 0, "R8"); probe(13'h1800, 0, "R8");
      probe(13'h1FFF, 0, "R8");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule